// File: doc/BRIEF.md
# Blinking Hardware Cursor Overlay

This block paints a one-bit-per-pixel cursor over a stream of display pixels. Each incoming pixel arrives with its panel coordinates. When the pixel falls inside the cursor rectangle, the matching bit of the cursor bitmap decides what goes out. A set bit replaces the pixel with the programmed cursor colour. A clear bit lets the pixel through untouched.

The bitmap is held in a private row memory with one 32-bit word per cursor row. A write port can update this memory at any moment, whether the display is streaming or idle.

The cursor can blink by itself. Blink timing is counted in whole frames, using a frame-start strobe. The cursor stays visible for one programmed number of frames, then hidden for a second programmed number, and the cycle repeats. A cursor size that cannot be represented suppresses the drawing and raises a sticky error flag, which software clears.

Top module: `cursor_overlay`

## Requirements
- R1: `pix_out` and `pix_out_valid` are registered. A pixel presented with `pix_valid` high in one cycle appears on `pix_out` in the next cycle, with `pix_out_valid` high. Any pixel that the cursor does not cover leaves equal to `pix_in`.
- R2: Inside the cursor rectangle, the bitmap word at row address `pix_y - cfg_y` is consulted. Column `c = pix_x - cfg_x` selects bit `31 - c`, so the leftmost pixel of a row is the most significant bit. A 1 outputs `cfg_color` and a 0 outputs `pix_in`.
- R3: A pixel is inside the rectangle only when `cfg_x <= pix_x < cfg_x + cfg_width` and `cfg_y <= pix_y < cfg_y + cfg_height`. When `cfg_enable` is 0, nothing is drawn.
- R4: When `bm_we` is high at a rising clock edge, `bm_wdata` is stored at row `bm_addr`. The write is accepted whether or not the cursor is enabled or pixels are streaming, and later pixels use the new row.
- R5: While `cfg_blink_en` is 1, the cursor is visible for `cfg_on_frames` frame strobes and then hidden for `cfg_off_frames` strobes, repeating. A count of 0 acts as 1. After `k` strobes counted from the enabling of blink, the cursor is visible exactly when `k mod (on+off) < on`.
- R6: While `cfg_blink_en` is 0, an enabled cursor is always visible and frame strobes have no effect. Enabling blink again restarts at the first visible frame.
- R7: A configuration is invalid when `cfg_width` or `cfg_height` is 0 or greater than 32. While `cfg_enable` is 1 and the configuration is invalid, nothing is drawn, and `cfg_err` is 1 from the next cycle on. An invalid size with `cfg_enable` at 0 does not raise `cfg_err`.
- R8: `cfg_err` stays set until a cycle with `err_clr` high clears it. If the configuration is still invalid and enabled in that cycle, setting wins and the flag stays 1.
- R9: During reset, `pix_out_valid`, `pix_out` and `cfg_err` are 0, and the blink state starts in its visible phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Cursor enable |
| cfg_blink_en | input | 1 | Automatic blink enable |
| cfg_width | input | 7 | Cursor width in pixels |
| cfg_height | input | 7 | Cursor height in rows |
| cfg_x | input | 12 | Left edge column |
| cfg_y | input | 12 | Top edge row |
| cfg_color | input | 24 | Colour of set bitmap bits |
| cfg_on_frames | input | 8 | Visible frames per blink period |
| cfg_off_frames | input | 8 | Hidden frames per blink period |
| err_clr | input | 1 | Clears the error flag |
| bm_we | input | 1 | Bitmap row write strobe |
| bm_addr | input | 5 | Bitmap row address |
| bm_wdata | input | 32 | Bitmap row data, MSB is leftmost |
| frame_start | input | 1 | One-cycle strobe at each frame start |
| pix_valid | input | 1 | Input pixel qualifier |
| pix_x | input | 12 | Input pixel column |
| pix_y | input | 12 | Input pixel row |
| pix_in | input | 24 | Input pixel colour |
| pix_out_valid | output | 1 | Output pixel qualifier |
| pix_out | output | 24 | Pixel after cursor overlay |
| cfg_err | output | 1 | Sticky invalid-configuration flag |

## Verification
The hardest situations to reach are the blink phase boundaries, above all the zero-count case in which each phase lasts a single frame. In real use these would need whole frames of streamed pixels. The bench avoids that by pulsing `frame_start` on its own and probing one covered pixel between strobes. It compares the result with `k mod (on+off)` for every strobe index over several periods. Exhaustive sweeps of small windows, which include the 1×1 and 32×32 edge sizes, cover every rectangle edge and every bitmap column.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  parameter int CUR_MAX = 32;   // bitmap row width and row count (power of two)
  parameter int COORD_W = 12;
  parameter int COLOR_W = 24;
  parameter int CNT_W   = 8;
  localparam int DIM_W  = $clog2(CUR_MAX) + 2;
  localparam int ROW_W  = $clog2(CUR_MAX);

  typedef logic [COORD_W-1:0] coord_t;
  typedef logic [DIM_W-1:0]   dim_t;
  typedef logic [COLOR_W-1:0] color_t;
  typedef logic [CUR_MAX-1:0] row_t;
  typedef logic [CNT_W-1:0]   cnt_t;
  typedef logic [ROW_W-1:0]   idx_t;

  // size is drawable: nonzero and no larger than the bitmap
  function automatic logic dim_ok(dim_t d);
    return (d != '0) && (d <= DIM_W'(CUR_MAX));
  endfunction

  // p lies within [start, start+len)
  function automatic logic in_span(coord_t p, coord_t start, dim_t len);
    coord_t off;
    off = p - start;
    return (p >= start) && (off < COORD_W'(len));
  endfunction

  function automatic idx_t offset_idx(coord_t p, coord_t start);
    coord_t d;
    d = p - start;
    return d[ROW_W-1:0];
  endfunction

  // leftmost column is the top bit of the row word
  function automatic logic pick_bit(row_t w, idx_t col);
    row_t sh;
    sh = w << col;
    return sh[CUR_MAX-1];
  endfunction

  // a phase length of zero behaves as one frame
  function automatic cnt_t phase_len(cnt_t n);
    return (n == '0) ? cnt_t'(1) : n;
  endfunction
endpackage

// File: rtl/cursor_bitmap_ram.sv
module cursor_bitmap_ram import cursor_pkg::*; (
  input  logic clk,
  input  logic we,
  input  idx_t waddr,
  input  row_t wdata,
  input  idx_t raddr,
  output row_t rdata
);
  row_t mem [CUR_MAX];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/cursor_blink.sv
module cursor_blink import cursor_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic blink_en,
  input  logic frame_start,
  input  cnt_t on_frames,
  input  cnt_t off_frames,
  output logic visible
);
  logic shown;
  cnt_t cnt;
  cnt_t cur_len;
  logic phase_done;
  logic toggle_evt;

  assign cur_len    = phase_len(shown ? on_frames : off_frames);
  assign phase_done = (cnt >= cur_len - cnt_t'(1));
  assign toggle_evt = blink_en && frame_start && phase_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shown <= 1'b1;
      cnt   <= '0;
    end else if (!blink_en) begin
      shown <= 1'b1;
      cnt   <= '0;
    end else if (frame_start) begin
      if (phase_done) begin
        shown <= ~shown;
        cnt   <= '0;
      end else begin
        cnt <= cnt + cnt_t'(1);
      end
    end
  end

  assign visible = shown;

  // R6
  blink_off_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blink_en |=> shown);
  // R5
  hold_between_frames_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blink_en && !frame_start) |=> $stable(shown));
  // R5
  phase_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    toggle_evt |=> (shown != $past(shown)));
endmodule

// File: rtl/cursor_window.sv
module cursor_window import cursor_pkg::*; (
  input  coord_t pix_x,
  input  coord_t pix_y,
  input  coord_t cur_x,
  input  coord_t cur_y,
  input  dim_t   width,
  input  dim_t   height,
  output logic   hit,
  output idx_t   row,
  output idx_t   col
);
  assign hit = in_span(pix_x, cur_x, width) && in_span(pix_y, cur_y, height);
  assign row = offset_idx(pix_y, cur_y);
  assign col = offset_idx(pix_x, cur_x);
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay import cursor_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_enable,
  input  logic               cfg_blink_en,
  input  logic [DIM_W-1:0]   cfg_width,
  input  logic [DIM_W-1:0]   cfg_height,
  input  logic [COORD_W-1:0] cfg_x,
  input  logic [COORD_W-1:0] cfg_y,
  input  logic [COLOR_W-1:0] cfg_color,
  input  logic [CNT_W-1:0]   cfg_on_frames,
  input  logic [CNT_W-1:0]   cfg_off_frames,
  input  logic               err_clr,
  input  logic               bm_we,
  input  logic [ROW_W-1:0]   bm_addr,
  input  logic [CUR_MAX-1:0] bm_wdata,
  input  logic               frame_start,
  input  logic               pix_valid,
  input  logic [COORD_W-1:0] pix_x,
  input  logic [COORD_W-1:0] pix_y,
  input  logic [COLOR_W-1:0] pix_in,
  output logic               pix_out_valid,
  output logic [COLOR_W-1:0] pix_out,
  output logic               cfg_err
);
  logic hit;
  idx_t row_idx;
  idx_t col_idx;
  row_t row_word;
  logic visible;
  logic bit_on;
  logic cfg_valid;
  logic cfg_bad;
  logic draw;

  cursor_window u_window (
    .pix_x (pix_x), .pix_y (pix_y), .cur_x (cfg_x), .cur_y (cfg_y),
    .width (cfg_width), .height (cfg_height),
    .hit (hit), .row (row_idx), .col (col_idx)
  );

  cursor_bitmap_ram u_ram (
    .clk (clk), .we (bm_we), .waddr (bm_addr), .wdata (bm_wdata),
    .raddr (row_idx), .rdata (row_word)
  );

  cursor_blink u_blink (
    .clk (clk), .rst_n (rst_n), .blink_en (cfg_blink_en),
    .frame_start (frame_start), .on_frames (cfg_on_frames),
    .off_frames (cfg_off_frames), .visible (visible)
  );

  assign bit_on    = pick_bit(row_word, col_idx);
  assign cfg_valid = dim_ok(cfg_width) && dim_ok(cfg_height);
  assign cfg_bad   = cfg_enable && !cfg_valid;
  assign draw      = cfg_enable && cfg_valid && visible && hit && bit_on;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_out_valid <= 1'b0;
      pix_out       <= '0;
      cfg_err       <= 1'b0;
    end else begin
      pix_out_valid <= pix_valid;
      pix_out       <= draw ? cfg_color : pix_in;
      if (cfg_bad)      cfg_err <= 1'b1;
      else if (err_clr) cfg_err <= 1'b0;
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> pix_out_valid);
  // R3
  outside_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !hit) |=> (pix_out == $past(pix_in)));
  // R2
  clear_bit_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !bit_on) |=> (pix_out == $past(pix_in)));
  // R7
  bad_cfg_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && cfg_bad) |=> (pix_out == $past(pix_in)));
  // R7
  err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bad |=> cfg_err);
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !err_clr) |=> cfg_err);
endmodule

// File: tb/test_cursor_overlay.sv
module test_cursor_overlay;
  import cursor_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_enable = 1'b0, cfg_blink_en = 1'b0, err_clr = 1'b0;
  logic [DIM_W-1:0] cfg_width = '0, cfg_height = '0;
  logic [COORD_W-1:0] cfg_x = '0, cfg_y = '0, pix_x = '0, pix_y = '0;
  logic [COLOR_W-1:0] cfg_color = '0, pix_in = '0;
  logic [CNT_W-1:0] cfg_on_frames = '0, cfg_off_frames = '0;
  logic bm_we = 1'b0, frame_start = 1'b0, pix_valid = 1'b0;
  logic [ROW_W-1:0] bm_addr = '0;
  logic [CUR_MAX-1:0] bm_wdata = '0;
  logic pix_out_valid, cfg_err;
  logic [COLOR_W-1:0] pix_out;

  logic [31:0] model [32];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cursor_overlay i_cursor_overlay (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] expect_pix(int x, int y, logic [23:0] pin, bit vis);
    int dx = x - int'(cfg_x);
    int dy = y - int'(cfg_y);
    int w = int'(cfg_width);
    int h = int'(cfg_height);
    bit ok = (w >= 1) && (w <= 32) && (h >= 1) && (h <= 32);
    if (cfg_enable && ok && vis && dx >= 0 && dx < w && dy >= 0 && dy < h && model[dy][31-dx])
      return cfg_color;
    return pin;
  endfunction

  task automatic wr(int addr, logic [31:0] data);
    @(negedge clk);
    bm_we = 1'b1; bm_addr = ROW_W'(addr); bm_wdata = data;
    model[addr] = data;
    @(negedge clk);
    bm_we = 1'b0;
  endtask

  task automatic px(int x, int y, logic [23:0] pin, bit vis, string tag);
    @(negedge clk);
    pix_valid = 1'b1; pix_x = COORD_W'(x); pix_y = COORD_W'(y); pix_in = pin;
    @(negedge clk);
    check(tag, {8'h0, pix_out}, {8'h0, expect_pix(x, y, pin, vis)});
  endtask

  task automatic frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic set_cfg(int x, int y, int w, int h);
    @(negedge clk);
    cfg_x = COORD_W'(x); cfg_y = COORD_W'(y);
    cfg_width = DIM_W'(w); cfg_height = DIM_W'(h);
  endtask

  task automatic blink_run(int on, int off, int n, string tag);
    int p;
    p = ((on == 0) ? 1 : on) + ((off == 0) ? 1 : off);
    @(negedge clk);
    cfg_on_frames = CNT_W'(on); cfg_off_frames = CNT_W'(off); cfg_blink_en = 1'b1;
    for (int k = 0; k < n; k++) begin
      px(0, 0, 24'h000000, (k % p) < ((on == 0) ? 1 : on), tag);
      frame();
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 32; r++) model[r] = 32'h0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 valid", {31'h0, pix_out_valid}, 32'h0);
    check("R9 pix", {8'h0, pix_out}, 32'h0);
    check("R9 err", {31'h0, cfg_err}, 32'h0);
    rst_n = 1'b1;

    // R4 bitmap loaded while cursor disabled
    for (int r = 0; r < 32; r++) wr(r, (32'h9E3779B9 * (r + 1)) ^ (r << 3));
    cfg_color = 24'h12AB34;

    // R3 disabled cursor draws nothing
    set_cfg(5, 3, 10, 7);
    for (int x = 4; x < 16; x++) px(x, 4, 24'h0F0F0F, 1, "R3 disabled");

    // R2 R3 sweep of a 10x7 window at (5,3)
    cfg_enable = 1'b1;
    for (int y = 0; y < 15; y++)
      for (int x = 0; x < 21; x++)
        px(x, y, {x[7:0], y[7:0], 8'h5A}, 1, "R2/R3 window");

    // R1 registered output and valid
    check("R1 valid high", {31'h0, pix_out_valid}, 32'h1);
    @(negedge clk); pix_valid = 1'b0;
    @(negedge clk);
    check("R1 valid low", {31'h0, pix_out_valid}, 32'h0);

    // R2 full 32x32 cursor, every column
    set_cfg(0, 0, 32, 32);
    for (int y = 0; y < 32; y++)
      for (int x = 0; x < 34; x++)
        px(x, y, 24'hC0FFEE ^ 24'(x * 7 + y), 1, "R2 full");

    // R3 1x1 cursor edges
    wr(0, 32'h8000_0000);
    set_cfg(100, 200, 1, 1);
    for (int y = 199; y < 202; y++)
      for (int x = 98; x < 103; x++)
        px(x, y, 24'h333333, 1, "R3 1x1 edge");

    // R4 writes while streaming
    set_cfg(8, 8, 16, 4);
    for (int r = 0; r < 4; r++) begin
      px(8 + r, 8 + r, 24'h010203, 1, "R4 before write");
      wr(r, ~model[r]);
      for (int x = 8; x < 24; x++) px(x, 8 + r, 24'h010203, 1, "R4 after write");
    end

    // R5 blink periods
    wr(0, 32'hFFFF_FFFF);
    set_cfg(0, 0, 4, 4);
    blink_run(2, 3, 12, "R5 blink 2/3");
    // R6 disabling forces visible, strobes ignored
    @(negedge clk); cfg_blink_en = 1'b0;
    px(0, 0, 24'h0, 1, "R6 forced visible");
    frame(); frame();
    px(0, 0, 24'h0, 1, "R6 strobe ignored");
    // R6 restart, R5 zero counts act as one
    blink_run(0, 0, 6, "R5 zero counts");
    @(negedge clk); cfg_blink_en = 1'b0;
    blink_run(1, 4, 11, "R6 restart 1/4");
    @(negedge clk); cfg_blink_en = 1'b0;

    // R7 invalid sizes
    set_cfg(0, 0, 0, 4);
    @(negedge clk);
    check("R7 err w=0", {31'h0, cfg_err}, 32'h1);
    px(0, 0, 24'h777777, 1, "R7 suppressed w=0");
    @(negedge clk); err_clr = 1'b1;
    // R8 set wins over clear while still invalid
    @(negedge clk); err_clr = 1'b0;
    check("R8 set wins", {31'h0, cfg_err}, 32'h1);
    set_cfg(0, 0, 4, 33);
    px(1, 1, 24'h777777, 1, "R7 suppressed h=33");
    set_cfg(0, 0, 4, 4);
    repeat (3) @(negedge clk);
    check("R8 sticky", {31'h0, cfg_err}, 32'h1);
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    check("R8 cleared", {31'h0, cfg_err}, 32'h0);
    px(1, 1, 24'h777777, 1, "R7 drawn when valid");
    @(negedge clk); cfg_enable = 1'b0;
    set_cfg(0, 0, 40, 0);
    repeat (2) @(negedge clk);
    check("R7 no err when disabled", {31'h0, cfg_err}, 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule